// File: doc/BRIEF.md
# SPI Daisy-Chain Register Target

This block is an SPI target built to be strung with identical copies into a chain. Every copy shares the serial clock and the active-low select. Each copy's serial output drives the serial input of the next, and the last output returns to the host. No copy has an address of its own. While select is low, each copy shifts a fixed 32-bit frame in on its serial input. At the same time it shifts out the frame it held from the previous transaction. A chain of N copies therefore behaves as one 32·N-bit shift register. The host sends one frame per copy, farthest copy first.

When select rises, each copy decodes the frame it holds and executes it, provided at least 32 bits were clocked in since select fell. A 12-bit address in the frame picks one of three targets. The first is one of eight downstream 256-byte windows: four ports with two logical devices each, reached through a request/response handshake. The second is the local register bank. The third is an invalid region. A read stores its result in the data byte of the held frame, so the result leaves on the serial output during the next transaction.

Serial inputs are synchronised into the system clock. The serial output enable follows select without any clock.

Top module: `spi_chain_target`

## Requirements
- R1: `misoOe` is high exactly while `ssN` is low, with no clock edge needed; `miso` carries bit 31 of the held frame before the first SCK edge.
- R2: Frame layout, MSB first: bits [31:24] command, where bit 24 = 1 means read and 0 means write; bits [23:20] are ignored; bits [19:8] hold the address; bits [7:0] hold the data. Bits are sampled on the SCK rising edge. During a transaction `miso` shifts out the frame held from the previous one, MSB first. After reset the held frame is all zeros.
- R3: A frame executes only on the rising edge of `ssN`, and only if at least 32 SCK rising edges occurred since `ssN` fell. A shorter frame performs no access, but its bits stay in the shift register.
- R4: An address with bit 11 = 0 raises `reqValid` with the following fields: `reqPort` = address[10:9], `reqDev` = address[8], `reqOffset` = address[7:0], and `reqWrite` = 1 for a write. These signals hold steady until a cycle with `respValid` high, and exactly one handshake occurs per frame.
- R5: A downstream write presents the frame's data byte on `reqWdata`. For a downstream read, `respRdata` replaces the data byte of the held frame.
- R6: Addresses 0x800–0x8FF reach the local bank, indexed by address[7:0]. Entry 0 resets to 0xA0 and entry 1 resets to 0xA2; the remaining entries reset to 0x00. All entries are writable. Offsets at or beyond the bank size read 0xFF and ignore writes.
- R7: `reqBusId` carries local entry 0 when `reqDev` = 0 and local entry 1 when `reqDev` = 1.
- R8: Addresses 0x900–0xFFF are invalid. A read there returns 0xFF, and a write there changes nothing and raises no request.
- R9: While `ssN` is high, SCK and MOSI activity leaves the held frame unchanged.
- R10: When more than 32 bits are clocked in during one transaction, the device keeps and executes the last 32 bits. Chained devices therefore each execute their own slice of one long transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, mode 0 |
| ssN | input | 1 | Active-low select shared by the chain |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for `miso`; low means high impedance |
| reqValid | output | 1 | Downstream request pending |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqPort | output | 2 | Downstream port number |
| reqDev | output | 1 | Logical device within the port |
| reqOffset | output | 8 | Byte offset within the device window |
| reqWdata | output | 8 | Write data |
| reqBusId | output | 8 | Bus identifier for the selected device |
| respValid | input | 1 | Downstream completion strobe |
| respRdata | input | 8 | Downstream read data |

## Verification
Two cases are hard to reach from the ports. The first is a short frame whose shifted contents would form a valid write had it executed. The bench creates one by first parking a write frame to an out-of-bank local offset. It then clocks only 8 zero bits, which turns that frame into a write of 0x00 to a live scratch entry, and reads the entry back unchanged. The second is the chain case. A second copy is wired behind the first, one 64-bit transaction is sent, and the downstream requests and the returned 64 bits show that each copy executed only its own 32-bit slice.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int CmdBits   = 8;
  localparam int AddrField = 16;
  localparam int AddrBits  = 12;
  localparam int DataBits  = 8;
  localparam int PortBits  = 2;
  localparam int FrameBits = CmdBits + AddrField + DataBits;
  localparam int CntBits   = $clog2(FrameBits + 1);
  localparam int ReadBit   = FrameBits - CmdBits;
  localparam int AddrLsb   = DataBits;

  typedef enum logic [1:0] {
    RD_LOCAL = 2'd0,
    RD_RESP  = 2'd1,
    RD_ONES  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   shiftIn;
    logic   shiftOut;
    logic   idleLoad;
    logic   loadData;
    rdSrc_e rdSrc;
    logic   localWe;
  } ctlStrobe_t;
endpackage

// File: rtl/spi_chain_dp.sv
module spi_chain_dp
  import spi_chain_pkg::*;
#(
  parameter int NumLocal = 4,
  parameter logic [DataBits-1:0] IdDefault0 = 8'hA0,
  parameter logic [DataBits-1:0] IdDefault1 = 8'hA2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic                mosiS,
  input  logic [DataBits-1:0] respRdata,
  output logic                frameRead,
  output logic [AddrBits-1:0] frameAddr,
  output logic [DataBits-1:0] frameData,
  output logic                outBit,
  output logic [DataBits-1:0] busId0,
  output logic [DataBits-1:0] busId1
);
  localparam int IdxBits = (NumLocal > 1) ? $clog2(NumLocal) : 1;
  localparam logic [DataBits-1:0] NumLocalW = DataBits'(NumLocal);

  logic [FrameBits-1:0] shReg;
  logic [DataBits-1:0]  regQ [NumLocal];
  logic [DataBits-1:0]  localIdx;
  logic                 inBank;
  logic [DataBits-1:0]  rdLocal;
  logic [DataBits-1:0]  rdVal;

  function automatic logic [DataBits-1:0] rstVal(input int idx);
    if (idx == 0) return IdDefault0;
    if (idx == 1) return IdDefault1;
    return '0;
  endfunction

  assign frameRead = shReg[ReadBit];
  assign frameAddr = shReg[AddrLsb +: AddrBits];
  assign frameData = shReg[DataBits-1:0];
  assign localIdx  = frameAddr[DataBits-1:0];
  assign inBank    = localIdx < NumLocalW;
  assign rdLocal   = inBank ? regQ[localIdx[IdxBits-1:0]] : '1;
  assign busId0    = regQ[0];
  assign busId1    = regQ[1];

  always_comb begin
    unique case (strb.rdSrc)
      RD_LOCAL: rdVal = rdLocal;
      RD_RESP:  rdVal = respRdata;
      default:  rdVal = '1;
    endcase
  end

  // Shift register: serial in on sampled rise, read result merged into data byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.shiftIn) begin
      shReg <= {shReg[FrameBits-2:0], mosiS};
    end else if (strb.loadData) begin
      shReg[DataBits-1:0] <= rdVal;
    end
  end

  // Output bit: tracks the MSB while idle, advances on each sampled fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit <= 1'b0;
    end else if (strb.idleLoad || strb.shiftOut) begin
      outBit <= shReg[FrameBits-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumLocal; i++) regQ[i] <= rstVal(i);
    end else if (strb.localWe && inBank) begin
      regQ[localIdx[IdxBits-1:0]] <= frameData;
    end
  end

  for (genvar g = 0; g < NumLocal; g++) begin : g_regChk
    // R6: local entries change only on a committed local write
    p_reg_commit_only_r6: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regQ[g]) |-> $past(strb.localWe));
  end
endmodule

// File: rtl/spi_chain_ctl.sv
module spi_chain_ctl
  import spi_chain_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sck,
  input  logic                ssN,
  input  logic                mosi,
  input  logic                frameRead,
  input  logic [AddrBits-1:0] frameAddr,
  input  logic [DataBits-1:0] frameData,
  input  logic                respValid,
  output ctlStrobe_t          strb,
  output logic                mosiS,
  output logic                reqValid,
  output logic                reqWrite,
  output logic [AddrBits-1:0] reqAddr,
  output logic [DataBits-1:0] reqWdata
);
  localparam logic [CntBits-1:0] FullCnt = CntBits'(FrameBits);
  localparam logic [3:0] LocalPage = 4'h8;

  logic [SyncStages-1:0] sckQ, ssQ, mosiQ;
  logic sckS, ssS, sckPrev, ssPrev;
  logic sckRise, sckFall, ssRise, active;
  logic [CntBits-1:0] bitCnt;
  logic commit, isPort, isLocal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= '0;
      ssQ     <= '1;
      mosiQ   <= '0;
      sckPrev <= 1'b0;
      ssPrev  <= 1'b1;
    end else begin
      sckQ    <= {sckQ[SyncStages-2:0], sck};
      ssQ     <= {ssQ[SyncStages-2:0], ssN};
      mosiQ   <= {mosiQ[SyncStages-2:0], mosi};
      sckPrev <= sckS;
      ssPrev  <= ssS;
    end
  end

  assign sckS    = sckQ[SyncStages-1];
  assign ssS     = ssQ[SyncStages-1];
  assign mosiS   = mosiQ[SyncStages-1];
  assign active  = ~ssS;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign ssRise  = ssS & ~ssPrev;

  // Counts sampled bits, saturating at one frame so longer chains keep the tail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ssRise) begin
      bitCnt <= '0;
    end else if (active && sckRise && bitCnt != FullCnt) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign isPort  = ~frameAddr[AddrBits-1];
  assign isLocal = frameAddr[AddrBits-1 -: 4] == LocalPage;
  assign commit  = ssRise && (bitCnt == FullCnt) && !reqValid;

  always_comb begin
    strb          = '0;
    strb.shiftIn  = active && sckRise;
    strb.shiftOut = active && sckFall;
    strb.idleLoad = ~active;
    strb.rdSrc    = RD_ONES;
    strb.localWe  = commit && isLocal && !frameRead;
    if (commit && frameRead && !isPort) begin
      strb.loadData = 1'b1;
      strb.rdSrc    = isLocal ? RD_LOCAL : RD_ONES;
    end else if (reqValid && respValid && !reqWrite) begin
      strb.loadData = 1'b1;
      strb.rdSrc    = RD_RESP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqWrite <= 1'b0;
      reqAddr  <= '0;
      reqWdata <= '0;
    end else if (commit && isPort) begin
      reqValid <= 1'b1;
      reqWrite <= ~frameRead;
      reqAddr  <= frameAddr;
      reqWdata <= frameData;
    end else if (reqValid && respValid) begin
      reqValid <= 1'b0;
    end
  end

  // R4: a pending request holds its fields until completion
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !respValid |=> reqValid && $stable(reqAddr) && $stable(reqWrite) && $stable(reqWdata));

  // R3: a request starts only after a full frame was counted
  p_req_full_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(bitCnt) == FullCnt);

  // R8: the invalid region never reaches the downstream side
  p_no_req_invalid_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !reqAddr[AddrBits-1]);

  // R10: the bit counter saturates at one frame
  p_cnt_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FullCnt);
endmodule

// File: rtl/spi_chain_target.sv
module spi_chain_target
  import spi_chain_pkg::*;
#(
  parameter int NumLocal   = 4,
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sck,
  input  logic                ssN,
  input  logic                mosi,
  output logic                miso,
  output logic                misoOe,
  output logic                reqValid,
  output logic                reqWrite,
  output logic [PortBits-1:0] reqPort,
  output logic                reqDev,
  output logic [DataBits-1:0] reqOffset,
  output logic [DataBits-1:0] reqWdata,
  output logic [DataBits-1:0] reqBusId,
  input  logic                respValid,
  input  logic [DataBits-1:0] respRdata
);
  ctlStrobe_t          strb;
  logic                mosiS, frameRead, outBit;
  logic [AddrBits-1:0] frameAddr, reqAddr;
  logic [DataBits-1:0] frameData, busId0, busId1;

  spi_chain_ctl #(.SyncStages(SyncStages)) uCtl (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ssN), .mosi(mosi),
    .frameRead(frameRead), .frameAddr(frameAddr), .frameData(frameData),
    .respValid(respValid), .strb(strb), .mosiS(mosiS),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata)
  );

  spi_chain_dp #(.NumLocal(NumLocal)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(mosiS), .respRdata(respRdata),
    .frameRead(frameRead), .frameAddr(frameAddr), .frameData(frameData),
    .outBit(outBit), .busId0(busId0), .busId1(busId1)
  );

  assign misoOe    = ~ssN;
  assign miso      = outBit;
  assign reqPort   = reqAddr[DataBits+1 +: PortBits];
  assign reqDev    = reqAddr[DataBits];
  assign reqOffset = reqAddr[DataBits-1:0];
  assign reqBusId  = reqDev ? busId1 : busId0;
endmodule

// File: tb/sim_spi_chain_target.sv
module sim_spi_chain_target;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, ssN = 1'b1, mosi = 1'b0, chainMode = 1'b0;
  logic ss1, hostMiso;
  logic miso [2];
  logic misoOe [2];
  logic reqValid [2];
  logic reqWrite [2];
  logic [1:0] reqPort [2];
  logic reqDev [2];
  logic [7:0] reqOffset [2];
  logic [7:0] reqWdata [2];
  logic [7:0] reqBusId [2];
  logic respValid [2];
  logic [7:0] respRdata [2];
  logic [1:0] dly [2];
  int nChecks = 0, nErrors = 0;

  typedef struct { int dev; bit wr; bit [11:0] addr; bit [7:0] wdata; bit [7:0] busId; } expReq_t;
  expReq_t sbq[$];

  always #2 clk = ~clk;

  assign ss1      = chainMode ? ssN : 1'b1;
  assign hostMiso = chainMode ? miso[1] : miso[0];

  spi_chain_target u0 (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ssN), .mosi(mosi),
    .miso(miso[0]), .misoOe(misoOe[0]), .reqValid(reqValid[0]), .reqWrite(reqWrite[0]),
    .reqPort(reqPort[0]), .reqDev(reqDev[0]), .reqOffset(reqOffset[0]), .reqWdata(reqWdata[0]),
    .reqBusId(reqBusId[0]), .respValid(respValid[0]), .respRdata(respRdata[0]));

  spi_chain_target u1 (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ss1), .mosi(miso[0]),
    .miso(miso[1]), .misoOe(misoOe[1]), .reqValid(reqValid[1]), .reqWrite(reqWrite[1]),
    .reqPort(reqPort[1]), .reqDev(reqDev[1]), .reqOffset(reqOffset[1]), .reqWdata(reqWdata[1]),
    .reqBusId(reqBusId[1]), .respValid(respValid[1]), .respRdata(respRdata[1]));

  function automatic logic [7:0] model(input logic [11:0] a);
    return a[7:0] ^ {a[10:8], 5'b0} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mk(input bit rd, input logic [11:0] a, input logic [7:0] d);
    return {7'h00, rd, 4'h0, a, d};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectReq(input int dev, input bit wr, input logic [11:0] a,
                           input logic [7:0] wd, input logic [7:0] bid);
    expReq_t e;
    e.dev = dev; e.wr = wr; e.addr = a; e.wdata = wd; e.busId = bid;
    sbq.push_back(e);
  endtask

  // Downstream responders: complete each request three cycles after it appears
  for (genvar d = 0; d < 2; d++) begin : g_resp
    always @(posedge clk) begin
      if (!rstN) begin
        respValid[d] <= 1'b0;
        respRdata[d] <= 8'h00;
        dly[d]       <= 2'd0;
      end else begin
        respValid[d] <= 1'b0;
        if (reqValid[d] && !respValid[d]) begin
          if (dly[d] == 2'd2) begin
            respValid[d] <= 1'b1;
            respRdata[d] <= model({1'b0, reqPort[d], reqDev[d], reqOffset[d]});
            dly[d]       <= 2'd0;
          end else begin
            dly[d] <= dly[d] + 2'd1;
          end
        end
      end
    end
  end

  // Monitor: pops the scoreboard on every completed handshake
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rstN && reqValid[d] && respValid[d]) begin
        if (sbq.size() == 0) begin
          chk("R8 unexpected request", 64'(d), 64'hFFFF);
        end else begin
          expReq_t e;
          e = sbq.pop_front();
          chk("R4 device", 64'(d), 64'(e.dev));
          chk("R4 write flag", 64'(reqWrite[d]), 64'(e.wr));
          chk("R4 address fields", 64'({1'b0, reqPort[d], reqDev[d], reqOffset[d]}), 64'(e.addr));
          if (e.wr) chk("R5 write data", 64'(reqWdata[d]), 64'(e.wdata));
          chk("R7 bus id", 64'(reqBusId[d]), 64'(e.busId));
        end
      end
    end
  end

  task automatic xfer(input logic [63:0] tx, input int n, output logic [63:0] rx);
    rx = '0;
    ssN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (8) @(negedge clk);
      sck = 1'b1;
      rx[i] = hostMiso;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    ssN = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] tx, input logic [31:0] expRx, input string tag);
    logic [63:0] rx;
    xfer(64'(tx), 32, rx);
    chk(tag, rx, 64'(expRx));
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [63:0] rx;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset oe low", 64'(misoOe[0]), 64'h0);
    chk("R4 reset no request", 64'(reqValid[0]), 64'h0);

    // R1: enable follows select with no clock edge
    @(negedge clk);
    ssN = 1'b0;
    #0.5;
    chk("R1 oe async", 64'(misoOe[0]), 64'h1);
    ssN = 1'b1;
    #0.5;
    chk("R1 oe release", 64'(misoOe[0]), 64'h0);
    repeat (10) @(negedge clk);

    frame(mk(1, 12'h800, 8'h00), 32'h0, "R2 reset frame zero");
    frame(mk(1, 12'h801, 8'h00), mk(1, 12'h800, 8'hA0), "R6 entry0 default");
    frame(mk(0, 12'h802, 8'h5B), mk(1, 12'h801, 8'hA2), "R6 entry1 default");
    frame(mk(1, 12'h802, 8'h00), mk(0, 12'h802, 8'h5B), "R2 write frame echoed");
    frame(mk(0, 12'h8FE, 8'h11), mk(1, 12'h802, 8'h5B), "R6 scratch written");
    frame(mk(1, 12'h8FF, 8'h00), mk(0, 12'h8FE, 8'h11), "R2 previous frame");
    frame(mk(0, 12'h800, 8'hB4), mk(1, 12'h8FF, 8'hFF), "R6 beyond bank reads FF");
    expectReq(0, 1, 12'h3C5, 8'h77, 8'hA2);
    frame(mk(0, 12'h3C5, 8'h77), mk(0, 12'h800, 8'hB4), "R4 downstream write");
    expectReq(0, 0, 12'h4A7, 8'h00, 8'hB4);
    frame(mk(1, 12'h4A7, 8'h00), mk(0, 12'h3C5, 8'h77), "R7 after id rewrite");

    // R9: clock and data activity with select high must not disturb the held frame
    for (int k = 0; k < 40; k++) begin
      mosi = k[0] ^ k[2];
      repeat (4) @(negedge clk);
      sck = ~sck;
    end
    sck = 1'b0;
    repeat (10) @(negedge clk);
    frame(mk(1, 12'h900, 8'h00), mk(1, 12'h4A7, model(12'h4A7)), "R5 R9 read result held");
    frame(mk(0, 12'hABC, 8'h99), mk(1, 12'h900, 8'hFF), "R8 invalid read FF");
    frame(mk(0, 12'h808, 8'h02), mk(0, 12'hABC, 8'h99), "R8 invalid write frame");

    // R3: 8 zero bits turn the held frame into a write of 0x00 to entry 2; it must not run
    xfer(64'h0, 8, rx);
    frame(mk(1, 12'h802, 8'h00), 32'h0808_0200, "R3 short frame bits kept");
    frame(mk(1, 12'h800, 8'h00), mk(1, 12'h802, 8'h5B), "R3 short frame not executed");
    expectReq(0, 1, 12'h001, 8'h00, 8'hB4);
    frame(mk(0, 12'h001, 8'h00), mk(1, 12'h800, 8'hB4), "R8 invalid write ignored");

    // R10: two-device chain, farthest device's frame first
    chainMode = 1'b1;
    repeat (10) @(negedge clk);
    expectReq(0, 1, 12'h123, 8'h42, 8'hA2);
    xfer({mk(1, 12'h801, 8'h00), mk(0, 12'h123, 8'h42)}, 64, rx);
    chk("R10 chain first", rx, {32'h0, mk(0, 12'h001, 8'h00)});
    expectReq(1, 1, 12'h234, 8'h10, 8'hA0);
    xfer({mk(0, 12'h234, 8'h10), mk(1, 12'h8FF, 8'h00)}, 64, rx);
    chk("R10 chain second", rx, {mk(1, 12'h801, 8'hA2), mk(0, 12'h123, 8'h42)});
    xfer({mk(1, 12'h802, 8'h00), mk(1, 12'h800, 8'h00)}, 64, rx);
    chk("R10 chain third", rx, {mk(0, 12'h234, 8'h10), mk(1, 12'h8FF, 8'hFF)});

    chk("R4 all requests seen", 64'(sbq.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule